// File: doc/BRIEF.md
# SDRAM Open-Page Tracker with Least-Recently-Used Closing

This block sits in a memory controller next to the command scheduler and records, for every DRAM bank, whether a row is open and which one. Every access request names a bank and a row. One clock later the block reports a classification: hit (the row is already open), miss (a different row is open), or empty (no row is open). With the classification it gives the row commands the scheduler must issue: a precharge (close a row), an activate (open a row), or both.

The number of rows that may be open at once is set at run time by an input. It can be anywhere from one up to the number of banks. Suppose an access finds its bank empty while that budget is already used up. The block then picks the open bank that was used least recently and closes it. That precharge targets a different bank from the one being activated, so the scheduler can issue it alongside the current access. A refresh request closes every bank at once.

Top module: `opt_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every command and result output is low, and every bank is empty, so the first access to any bank is classified empty.
- R2: An access presented with acc_valid_i high (and refresh_i low) produces exactly one cycle of res_valid_o on the next cycle. res_kind_o is coded 2'b00 for empty, 2'b01 for hit and 2'b10 for miss; 2'b11 never appears.
- R3: A hit issues no precharge and no activate, leaves the row open, and makes that bank the most recently used.
- R4: A miss asserts pre_o and act_o together, both naming the accessed bank, with act_row_o equal to the new row. The precharge is to be issued first. The bank stays open with the new row and becomes the most recently used.
- R5: An empty access made while fewer banks are open than the limit asserts act_o for the accessed bank and row, with no precharge. The bank becomes open and the most recently used.
- R6: An empty access made while the number of open banks is equal to or greater than the limit also asserts pre_o in the same result cycle. pre_bank_o names the open bank whose last use is oldest, and that bank becomes empty. The count of open banks therefore does not rise.
- R7: An open_limit_i value of 0 is treated as 1. Values above NUM_BANKS are treated as NUM_BANKS.
- R8: refresh_i produces pre_all_o on the next cycle and leaves every bank empty. An access presented in the same cycle as the refresh is dropped: it gives no result and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request strobe |
| acc_bank_i | input | BANK_W (3) | Bank index of the access |
| acc_row_i | input | ROW_W (12) | Row address of the access |
| refresh_i | input | 1 | Request to close all banks |
| open_limit_i | input | CNT_W (4) | Maximum number of open rows |
| res_valid_o | output | 1 | Classification valid |
| res_kind_o | output | 2 | 00 empty, 01 hit, 10 miss |
| pre_o | output | 1 | Single-bank precharge request |
| pre_bank_o | output | BANK_W (3) | Bank to precharge |
| act_o | output | 1 | Activate request |
| act_bank_o | output | BANK_W (3) | Bank to activate |
| act_row_o | output | ROW_W (12) | Row to activate |
| pre_all_o | output | 1 | Precharge-all request |

## Verification
The tracker is swept across every limit value from 0 to 9, including the two values that must be clamped. Each limit gets a forty-access pattern that steps through banks and rows arithmetically, so hits, misses, under-budget opens and evicting opens occur mixed together in changing recency orders. A mistake in the eviction victim shows up as a wrong pre_bank_o, which separates least-recently-used choice from index order or most-recent order. A mistake in the budget comparison or the clamping shows up as a precharge that is missing or that should not be there. Each sweep starts with a refresh that carries a simultaneous access. The next access to that bank must then read empty, which shows that the refresh really cleared the state and that the competing access was dropped.

// File: rtl/opt_pkg.sv
package opt_pkg;
  typedef enum logic [1:0] {
    KIND_EMPTY = 2'b00,
    KIND_HIT   = 2'b01,
    KIND_MISS  = 2'b10
  } kind_e;
endpackage

// File: rtl/opt_lru.sv
// Recency rank per bank: 0 = most recent, NUM_BANKS-1 = oldest.
module opt_lru #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [BANK_W-1:0]    touch_bank_i,
  input  logic [NUM_BANKS-1:0] cand_i,
  output logic [BANK_W-1:0]    victim_o
);
  logic [BANK_W-1:0] age_q [NUM_BANKS];
  logic [BANK_W-1:0] touch_age;

  assign touch_age = age_q[touch_bank_i];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= BANK_W'(NUM_BANKS - 1 - g);
      end else if (touch_i) begin
        if (touch_bank_i == BANK_W'(g)) begin
          age_q[g] <= '0;
        end else if (age_q[g] < touch_age) begin
          age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end
  end

  // oldest among candidates; ranks are unique so the pick is unique
  always_comb begin
    logic              found;
    logic [BANK_W-1:0] best;
    found    = 1'b0;
    best     = '0;
    victim_o = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (cand_i[i] && (!found || age_q[i] > best)) begin
        found    = 1'b1;
        best     = age_q[i];
        victim_o = BANK_W'(i);
      end
    end
  end
endmodule

// File: rtl/opt_bank_table.sv
module opt_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_all_i,
  input  logic                 open_en_i,
  input  logic [BANK_W-1:0]    open_bank_i,
  input  logic [ROW_W-1:0]     open_row_i,
  input  logic                 close_en_i,
  input  logic [BANK_W-1:0]    close_bank_i,
  input  logic [BANK_W-1:0]    look_bank_i,
  output logic                 look_open_o,
  output logic [ROW_W-1:0]     look_row_o,
  output logic [NUM_BANKS-1:0] open_mask_o,
  output logic [CNT_W-1:0]     open_cnt_o
);
  logic             open_q [NUM_BANKS];
  logic [ROW_W-1:0] row_q  [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[g] <= 1'b0;
        row_q[g]  <= '0;
      end else if (clr_all_i) begin
        open_q[g] <= 1'b0;
      end else if (open_en_i && open_bank_i == BANK_W'(g)) begin
        open_q[g] <= 1'b1;
        row_q[g]  <= open_row_i;
      end else if (close_en_i && close_bank_i == BANK_W'(g)) begin
        open_q[g] <= 1'b0;
      end
    end
  end

  assign look_open_o = open_q[look_bank_i];
  assign look_row_o  = row_q[look_bank_i];

  always_comb begin
    open_cnt_o = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      open_mask_o[i] = open_q[i];
      open_cnt_o     = open_cnt_o + CNT_W'(open_q[i]);
    end
  end
endmodule

// File: rtl/opt_tracker.sv
module opt_tracker
  import opt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [BANK_W-1:0] acc_bank_i,
  input  logic [ROW_W-1:0]  acc_row_i,
  input  logic              refresh_i,
  input  logic [CNT_W-1:0]  open_limit_i,
  output logic              res_valid_o,
  output logic [1:0]        res_kind_o,
  output logic              pre_o,
  output logic [BANK_W-1:0] pre_bank_o,
  output logic              act_o,
  output logic [BANK_W-1:0] act_bank_o,
  output logic [ROW_W-1:0]  act_row_o,
  output logic              pre_all_o
);
  logic                 acc_go;
  logic                 look_open;
  logic [ROW_W-1:0]     look_row;
  logic [NUM_BANKS-1:0] open_mask;
  logic [CNT_W-1:0]     open_cnt;
  logic [CNT_W-1:0]     lim_eff;
  logic [BANK_W-1:0]    victim;
  logic                 is_hit, is_miss, is_empty, need_evict;
  kind_e                kind_d;

  assign acc_go = acc_valid_i && !refresh_i;  // refresh wins

  opt_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_all_i    (refresh_i),
    .open_en_i    (acc_go && !is_hit),
    .open_bank_i  (acc_bank_i),
    .open_row_i   (acc_row_i),
    .close_en_i   (need_evict),
    .close_bank_i (victim),
    .look_bank_i  (acc_bank_i),
    .look_open_o  (look_open),
    .look_row_o   (look_row),
    .open_mask_o  (open_mask),
    .open_cnt_o   (open_cnt)
  );

  opt_lru #(.NUM_BANKS(NUM_BANKS)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (acc_go),
    .touch_bank_i (acc_bank_i),
    .cand_i       (open_mask),
    .victim_o     (victim)
  );

  always_comb begin
    if (open_limit_i == '0)                       lim_eff = CNT_W'(1);
    else if (open_limit_i > CNT_W'(NUM_BANKS))    lim_eff = CNT_W'(NUM_BANKS);
    else                                          lim_eff = open_limit_i;
  end

  assign is_hit     = look_open && (look_row == acc_row_i);
  assign is_miss    = look_open && !is_hit;
  assign is_empty   = !look_open;
  assign need_evict = acc_go && is_empty && (open_cnt >= lim_eff);

  always_comb begin
    if (is_hit)       kind_d = KIND_HIT;
    else if (is_miss) kind_d = KIND_MISS;
    else              kind_d = KIND_EMPTY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_kind_o  <= KIND_EMPTY;
      pre_o       <= 1'b0;
      pre_bank_o  <= '0;
      act_o       <= 1'b0;
      act_bank_o  <= '0;
      act_row_o   <= '0;
      pre_all_o   <= 1'b0;
    end else begin
      res_valid_o <= acc_go;
      pre_o       <= acc_go && (is_miss || need_evict);
      act_o       <= acc_go && !is_hit;
      pre_all_o   <= refresh_i;
      if (acc_go) begin
        res_kind_o <= kind_d;
        pre_bank_o <= is_miss ? acc_bank_i : victim;
        act_bank_o <= acc_bank_i;
        act_row_o  <= acc_row_i;
      end
    end
  end
endmodule

// File: rtl/opt_tracker_chk.sv
module opt_tracker_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 12,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CNT_W  = $clog2(NUM_BANKS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic [BANK_W-1:0] acc_bank_i,
  input logic [ROW_W-1:0]  acc_row_i,
  input logic              refresh_i,
  input logic [CNT_W-1:0]  open_limit_i,
  input logic              res_valid_o,
  input logic [1:0]        res_kind_o,
  input logic              pre_o,
  input logic [BANK_W-1:0] pre_bank_o,
  input logic              act_o,
  input logic [BANK_W-1:0] act_bank_o,
  input logic [ROW_W-1:0]  act_row_o,
  input logic              pre_all_o,
  input logic [CNT_W-1:0]  open_cnt
);
  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> res_kind_o != 2'b11); // R2

  AST_ACC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !refresh_i) |=> (res_valid_o && act_bank_o == $past(acc_bank_i)
                                     && act_row_o == $past(acc_row_i))); // R2

  AST_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == 2'b01) |-> (!pre_o && !act_o)); // R3

  AST_MISS_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == 2'b10) |-> (pre_o && act_o && pre_bank_o == act_bank_o)); // R4

  AST_EMPTY_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == 2'b00) |-> act_o); // R5

  AST_EVICT_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == 2'b00 && pre_o) |-> pre_bank_o != act_bank_o); // R6

  AST_EVICT_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_kind_o == 2'b00 && pre_o) |-> open_cnt == $past(open_cnt)); // R6

  AST_REFRESH_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (pre_all_o && !res_valid_o && !pre_o && !act_o && open_cnt == '0)); // R8
endmodule

bind opt_tracker opt_tracker_chk #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/sim_opt_tracker.sv
module sim_opt_tracker;
  localparam int NB = 8;
  localparam int RW = 12;
  localparam int BW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [BW-1:0] acc_bank = '0;
  logic [RW-1:0] acc_row = '0;
  logic          refresh = 1'b0;
  logic [CW-1:0] limit = CW'(NB);
  logic          res_valid, pre, act, pre_all;
  logic [1:0]    res_kind;
  logic [BW-1:0] pre_bank, act_bank;
  logic [RW-1:0] act_row;

  int total = 0;
  int bad   = 0;

  // reference state: open flag, row, last-use stamp
  bit       m_open  [NB];
  int       m_row   [NB];
  int       m_stamp [NB];
  int       tnow = 0;

  always #4 clk = ~clk;

  opt_tracker #(.NUM_BANKS(NB), .ROW_W(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_bank_i(acc_bank),
    .acc_row_i(acc_row), .refresh_i(refresh), .open_limit_i(limit),
    .res_valid_o(res_valid), .res_kind_o(res_kind), .pre_o(pre), .pre_bank_o(pre_bank),
    .act_o(act), .act_bank_o(act_bank), .act_row_o(act_row), .pre_all_o(pre_all)
  );

  function automatic logic [23:0] pack_out(bit v, logic [1:0] k, bit p, logic [BW-1:0] pb,
                                           bit a, logic [BW-1:0] ab, logic [RW-1:0] ar, bit pa);
    return {v, k, p, (p ? pb : 3'd0), a, (a ? ab : 3'd0), (a ? ar : 12'd0), pa};
  endfunction

  task automatic check(string tag, logic [23:0] got, logic [23:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] actual();
    return pack_out(res_valid, res_kind, pre, pre_bank, act, act_bank, act_row, pre_all);
  endfunction

  task automatic do_access(int b, int r, int lim);
    int lim_e, cnt, vic;
    logic [23:0] exp;
    string tag;
    lim_e = (lim == 0) ? 1 : (lim > NB ? NB : lim);
    @(negedge clk);
    acc_valid = 1'b1; acc_bank = BW'(b); acc_row = RW'(r); limit = CW'(lim);
    if (m_open[b] && m_row[b] == r) begin
      tag = "R2 R3 hit";
      exp = pack_out(1, 2'b01, 0, 0, 0, 0, 0, 0);
    end else if (m_open[b]) begin
      tag = "R2 R4 miss";
      exp = pack_out(1, 2'b10, 1, BW'(b), 1, BW'(b), RW'(r), 0);
    end else begin
      cnt = 0;
      vic = -1;
      for (int i = 0; i < NB; i++) if (m_open[i]) begin
        cnt++;
        if (vic < 0 || m_stamp[i] < m_stamp[vic]) vic = i;
      end
      if (cnt >= lim_e) begin
        tag = "R6 evict";
        exp = pack_out(1, 2'b00, 1, BW'(vic), 1, BW'(b), RW'(r), 0);
        m_open[vic] = 0;
      end else begin
        tag = "R5 open";
        exp = pack_out(1, 2'b00, 0, 0, 1, BW'(b), RW'(r), 0);
      end
    end
    if (lim < 1 || lim > NB) tag = {tag, " R7 clamp"};
    m_open[b] = 1; m_row[b] = r; m_stamp[b] = tnow; tnow++;
    @(posedge clk); #2;
    check(tag, actual(), exp);
    acc_valid = 1'b0;
  endtask

  // refresh with a competing access that must be dropped
  task automatic do_refresh(int b);
    @(negedge clk);
    refresh = 1'b1; acc_valid = 1'b1; acc_bank = BW'(b); acc_row = RW'(7);
    for (int i = 0; i < NB; i++) m_open[i] = 0;
    @(posedge clk); #2;
    check("R8 refresh", actual(), pack_out(0, res_kind, 0, 0, 0, 0, 0, 1));
    refresh = 1'b0; acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; m_stamp[i] = i - NB; end
    repeat (3) @(posedge clk);
    #2 check("R1 in reset", actual(), 24'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 after reset", actual(), 24'd0);
    // R1: every bank first reads empty
    for (int b = 0; b < NB; b++) do_access(b, b + 1, NB);
    // sweep every limit, including the clamped values 0 and 9 (R7)
    for (int lim = 0; lim <= 9; lim++) begin
      do_refresh(lim % NB);
      do_access(lim % NB, 3, lim);  // R8: dropped access left bank empty
      for (int i = 0; i < 40; i++) begin
        do_access((i * 3 + i / 4 + lim) % NB, (i * i + i / 3) % 3, lim);
      end
    end
    repeat (2) @(posedge clk);
    #2 check("R2 idle", actual() & 24'h800000, 24'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule